// File: doc/BRIEF.md
# Lane Frame Sample Unpacker

This block sits directly after the link layer of one high-speed serial lane. The link layer delivers already-decoded 32-bit words. Every pair of consecutive words carries one 64-bit frame. Each frame holds five 12-bit offset-binary converter samples, packed most significant bit first and running straight across octet and word boundaries, followed by a 4-bit tail. The unpacker gathers the two halves and slices out the five samples. It drops the tail and presents all five samples together on one wide bus, qualified by a single-cycle valid pulse.

A frame-start marker comes in with the word stream and keeps the word-pair phase aligned. A marker that lands where the second half of a frame was expected is reported on an alignment-error pulse, and the pairing restarts from that word. A format input selects either raw offset-binary samples or two's-complement samples. The two's-complement form is the same value with its top bit inverted.

The word-pair phase is a two-state machine. In `PH_FIRST`, a valid word is stored as the first half, and the transition `take_first` moves the machine to `PH_SECOND`. In `PH_SECOND`, three things can happen:
- A valid word without a marker completes the frame. The transition `take_second` returns the machine to `PH_FIRST`.
- A valid word with a marker takes the transition `resync`. That word replaces the stored half, the error pulse fires, and the machine stays in `PH_SECOND`.
- An idle cycle takes the transition `hold`. Nothing changes.

Top module: `lane_sample_unpack`

## Requirements
- R1: After reset, `out_valid` and `align_err` are 0 and `out_samples` is all zeros.
- R2: The first accepted word of a pair supplies frame bits 63:32 and the second supplies bits 31:0. Octet 0 of the frame is bits 31:24 of the first word.
- R3: Sample k (k = 0 earliest to 4 latest) is frame bits [63-12k : 52-12k] and appears on `out_samples[12k+11:12k]`. The octets 00 0F FF 00 0F FF 00 00 therefore give samples 000, FFF, 000, FFF, 000 (hex).
- R4: Frame bits 3:0 (the tail) have no effect on any output.
- R5: `out_valid` is high for exactly the one cycle after the clock edge that accepts a second word. It is never high on two consecutive cycles.
- R6: While `out_valid` is low, `out_samples` keeps its last value.
- R7: When `in_valid` is low between the two halves, the stored first half is kept, and the frame completes with the next valid word.
- R8: With `fmt_twos` = 1 (sampled together with the second word), bit 11 of every sample is inverted. With 0, samples pass unchanged.
- R9: A valid word with `in_sof` = 1 in second-half position makes `align_err` high for the next cycle and produces no frame. That word becomes the first half of the next frame.
- R10: `align_err` never rises for a marker on a first-half word, and `align_err` and `out_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded word present this cycle |
| in_sof | input | 1 | Word is the first half of a frame |
| in_word | input | 32 | Decoded lane word, earliest octet in bits 31:24 |
| fmt_twos | input | 1 | 1 selects two's-complement samples, 0 offset binary |
| out_valid | output | 1 | One-cycle pulse: a new set of samples is on `out_samples` |
| out_samples | output | 60 | Five 12-bit samples, sample 0 in bits 11:0 |
| align_err | output | 1 | One-cycle pulse: frame marker seen on a second-half word |

## Verification
The checker assumes that `in_sof` only carries meaning when `in_valid` is high. It also assumes that a frame's two halves are presented in order, with any number of idle cycles allowed between them. The bench holds to this:
- It drives words only on falling edges, and always clears `in_sof` when `in_valid` is low.
- It opens every frame with a marked first word.
- It creates a misaligned marker only in the dedicated resynchronisation case.

The main sweep steps sample 0 through all 4096 codes while the other samples, the tail, the format bit and the gap length vary arithmetically.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

    // Word-pair phase of the frame collector
    typedef enum logic [0:0] {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pair_phase_t;

    // Default lane geometry
    localparam int unsigned LANE_WORD_W = 32;
    localparam int unsigned SAMPLE_W    = 12;
    localparam int unsigned SAMPLES_PER = 5;

endpackage

// File: rtl/unpack_phase_fsm.sv
module unpack_phase_fsm
    import unpack_pkg::*;
#(
    parameter int unsigned WORD_W = LANE_WORD_W,
    localparam int unsigned FRAME_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [WORD_W-1:0] in_word,
    output logic              frame_fire,
    output logic              mark_err,
    output logic [FRAME_W-1:0] frame_bits
);

    pair_phase_t phase_q;
    pair_phase_t phase_d;
    logic [WORD_W-1:0] half_q;
    logic              load_half;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_FIRST;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Stored first half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
        end else if (load_half) begin
            half_q <= in_word;
        end
    end

    // Next state and outputs
    always_comb begin
        phase_d    = phase_q;
        load_half  = 1'b0;
        frame_fire = 1'b0;
        mark_err   = 1'b0;
        unique case (phase_q)
            PH_FIRST: begin
                if (in_valid) begin        // take_first
                    load_half = 1'b1;
                    phase_d   = PH_SECOND;
                end
            end
            PH_SECOND: begin
                if (in_valid && in_sof) begin          // resync
                    load_half = 1'b1;
                    mark_err  = 1'b1;
                    phase_d   = PH_SECOND;
                end else if (in_valid) begin           // take_second
                    frame_fire = 1'b1;
                    phase_d    = PH_FIRST;
                end else begin                         // hold
                    phase_d = PH_SECOND;
                end
            end
            default: begin
                phase_d = PH_FIRST;
            end
        endcase
    end

    assign frame_bits = {half_q, in_word};

endmodule

// File: rtl/unpack_slicer.sv
module unpack_slicer
    import unpack_pkg::*;
#(
    parameter int unsigned SAMP_W   = SAMPLE_W,
    parameter int unsigned NUM_SAMP = SAMPLES_PER,
    parameter int unsigned FRAME_W  = 2 * LANE_WORD_W,
    localparam int unsigned PAY_W   = SAMP_W * NUM_SAMP,
    localparam int unsigned TAIL_W  = FRAME_W - PAY_W
) (
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               fmt_twos,
    output logic [PAY_W-1:0]   samples
);

    logic [SAMP_W-1:0] flip_mask;
    logic              tail_unused;

    assign flip_mask   = {fmt_twos, {(SAMP_W-1){1'b0}}};
    assign tail_unused = ^frame_bits[TAIL_W-1:0];

    for (genvar k = 0; k < NUM_SAMP; k++) begin : g_lane_sample
        localparam int unsigned TOP = FRAME_W - 1 - k * SAMP_W;
        logic [SAMP_W-1:0] raw;
        assign raw = frame_bits[TOP -: SAMP_W];
        assign samples[k*SAMP_W +: SAMP_W] = raw ^ flip_mask;
    end

endmodule

// File: rtl/unpack_out_stage.sv
module unpack_out_stage #(
    parameter int unsigned PAY_W = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_fire,
    input  logic             mark_err,
    input  logic [PAY_W-1:0] samples_d,
    output logic             out_valid,
    output logic             align_err,
    output logic [PAY_W-1:0] out_samples
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            align_err <= 1'b0;
        end else begin
            out_valid <= frame_fire;
            align_err <= mark_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_samples <= '0;
        end else if (frame_fire) begin
            out_samples <= samples_d;
        end
    end

endmodule

// File: rtl/lane_sample_unpack.sv
module lane_sample_unpack
    import unpack_pkg::*;
#(
    parameter int unsigned WORD_W   = LANE_WORD_W,
    parameter int unsigned SAMP_W   = SAMPLE_W,
    parameter int unsigned NUM_SAMP = SAMPLES_PER,
    localparam int unsigned FRAME_W = 2 * WORD_W,
    localparam int unsigned PAY_W   = SAMP_W * NUM_SAMP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [WORD_W-1:0] in_word,
    input  logic              fmt_twos,
    output logic              out_valid,
    output logic [PAY_W-1:0]  out_samples,
    output logic              align_err
);

    logic               frame_fire;
    logic               mark_err;
    logic [FRAME_W-1:0] frame_bits;
    logic [PAY_W-1:0]   samples_d;

    unpack_phase_fsm #(
        .WORD_W (WORD_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_word    (in_word),
        .frame_fire (frame_fire),
        .mark_err   (mark_err),
        .frame_bits (frame_bits)
    );

    unpack_slicer #(
        .SAMP_W   (SAMP_W),
        .NUM_SAMP (NUM_SAMP),
        .FRAME_W  (FRAME_W)
    ) u_slice (
        .frame_bits (frame_bits),
        .fmt_twos   (fmt_twos),
        .samples    (samples_d)
    );

    unpack_out_stage #(
        .PAY_W (PAY_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_fire  (frame_fire),
        .mark_err    (mark_err),
        .samples_d   (samples_d),
        .out_valid   (out_valid),
        .align_err   (align_err),
        .out_samples (out_samples)
    );

endmodule

// File: rtl/unpack_checker.sv
module unpack_checker #(
    parameter int unsigned PAY_W = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic             out_valid,
    input logic [PAY_W-1:0] out_samples,
    input logic             align_err
);

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);                                        // R5

    AST_VALID_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !in_sof));                        // R5

    AST_SAMPLES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_samples));                             // R6

    AST_ERR_FROM_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> $past(in_valid && in_sof));                         // R9

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(align_err && out_valid));                                       // R10

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        align_err && !$past(in_valid && in_sof) |-> 1'b0);                // R10

endmodule

bind lane_sample_unpack unpack_checker #(
    .PAY_W (PAY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .out_valid   (out_valid),
    .out_samples (out_samples),
    .align_err   (align_err)
);

// File: tb/sim_lane_sample_unpack.sv
module sim_lane_sample_unpack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [31:0] in_word = '0;
    logic        fmt_twos = 1'b0;
    logic        out_valid;
    logic [59:0] out_samples;
    logic        align_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lane_sample_unpack u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sof      (in_sof),
        .in_word     (in_word),
        .fmt_twos    (fmt_twos),
        .out_valid   (out_valid),
        .out_samples (out_samples),
        .align_err   (align_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w, input logic s);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        in_sof   = s;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    function automatic logic [63:0] pack(input logic [11:0] a, b, c, d, e, input logic [3:0] t);
        return {a, b, c, d, e, t};
    endfunction

    function automatic logic [59:0] expect_out(input logic [11:0] a, b, c, d, e, input logic m);
        logic [11:0] f;
        f = {m, 11'b0};
        return {e ^ f, d ^ f, c ^ f, b ^ f, a ^ f};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] fr;
        logic [63:0] fr2;
        logic [59:0] ex;
        logic [59:0] held;
        logic [11:0] s [5];

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        chk(align_err == 1'b0, "R1 align_err", 64'(align_err), 64'd0);
        chk(out_samples == '0, "R1 samples", 64'(out_samples), 64'd0);
        rst_n = 1'b1;
        idle();

        // R3: worked octet example, raw format
        fmt_twos = 1'b0;
        fr = 64'h000F_FF00_0FFF_0000;
        put(fr[63:32], 1'b1);
        put(fr[31:0], 1'b0);
        idle();
        chk(out_valid == 1'b1, "R3 valid", 64'(out_valid), 64'd1);
        chk(out_samples == 60'h000_FFF_000_FFF_000, "R3 example", 64'(out_samples), 64'h000FFF000FFF000);

        // R2/R3/R5/R6/R7/R8/R10 sweep: sample 0 through every code
        for (int v = 0; v < 4096; v++) begin
            for (int k = 0; k < 5; k++) s[k] = 12'((v * (2 * k + 1) + k * 1365) & 12'hFFF);
            fr = pack(s[0], s[1], s[2], s[3], s[4], 4'(v));
            fmt_twos = v[0] ^ v[5];
            ex = expect_out(s[0], s[1], s[2], s[3], s[4], fmt_twos);
            put(fr[63:32], 1'b1);
            for (int g = 0; g < v % 3; g++) begin
                idle();
                chk(out_valid == 1'b0, "R7 gap no output", 64'(out_valid), 64'd0);
            end
            put(fr[31:0], 1'b0);
            idle();
            chk(out_valid == 1'b1, "R5 valid pulse", 64'(out_valid), 64'd1);
            chk(align_err == 1'b0, "R10 no error", 64'(align_err), 64'd0);
            chk(out_samples == ex, "R2 R3 R8 samples", 64'(out_samples), 64'(ex));
            if (v % 64 == 0) begin
                held = out_samples;
                idle();
                chk(out_valid == 1'b0, "R5 pulse ends", 64'(out_valid), 64'd0);
                chk(out_samples == held, "R6 samples held", 64'(out_samples), 64'(held));
            end
        end

        // R4: tail value has no effect
        fmt_twos = 1'b0;
        fr = pack(12'h123, 12'h456, 12'h789, 12'hABC, 12'hDEF, 4'h0);
        put(fr[63:32], 1'b1); put(fr[31:0], 1'b0); idle();
        held = out_samples;
        fr = pack(12'h123, 12'h456, 12'h789, 12'hABC, 12'hDEF, 4'hF);
        put(fr[63:32], 1'b1); put(fr[31:0], 1'b0); idle();
        chk(out_samples == held, "R4 tail ignored", 64'(out_samples), 64'(held));
        chk(out_samples == expect_out(12'h123, 12'h456, 12'h789, 12'hABC, 12'hDEF, 1'b0),
            "R4 tail value", 64'(out_samples), 64'h0);

        // R5: back-to-back frames, pulse per frame only
        fr  = pack(12'h001, 12'h002, 12'h003, 12'h004, 12'h005, 4'h9);
        fr2 = pack(12'hFFE, 12'hFFD, 12'hFFC, 12'hFFB, 12'hFFA, 4'h6);
        put(fr[63:32], 1'b1);
        put(fr[31:0], 1'b0);
        put(fr2[63:32], 1'b1);
        chk(out_valid == 1'b1, "R5 first of pair", 64'(out_valid), 64'd1);
        ex = expect_out(12'h001, 12'h002, 12'h003, 12'h004, 12'h005, 1'b0);
        chk(out_samples == ex, "R5 first samples", 64'(out_samples), 64'(ex));
        put(fr2[31:0], 1'b0);
        chk(out_valid == 1'b0, "R5 not consecutive", 64'(out_valid), 64'd0);
        idle();
        ex = expect_out(12'hFFE, 12'hFFD, 12'hFFC, 12'hFFB, 12'hFFA, 1'b0);
        chk(out_valid == 1'b1, "R5 second of pair", 64'(out_valid), 64'd1);
        chk(out_samples == ex, "R5 second samples", 64'(out_samples), 64'(ex));

        // R9: marker on a second-half word resynchronises
        fr = pack(12'h0AA, 12'h0BB, 12'h0CC, 12'h0DD, 12'h0EE, 4'h0);
        held = out_samples;
        put(32'hDEAD_BEEF, 1'b1);
        put(fr[63:32], 1'b1);
        idle();
        chk(align_err == 1'b1, "R9 error pulse", 64'(align_err), 64'd1);
        chk(out_valid == 1'b0, "R9 no frame", 64'(out_valid), 64'd0);
        chk(out_samples == held, "R9 samples unchanged", 64'(out_samples), 64'(held));
        put(fr[31:0], 1'b0);
        idle();
        ex = expect_out(12'h0AA, 12'h0BB, 12'h0CC, 12'h0DD, 12'h0EE, 1'b0);
        chk(align_err == 1'b0, "R9 error cleared", 64'(align_err), 64'd0);
        chk(out_valid == 1'b1, "R9 resync frame", 64'(out_valid), 64'd1);
        chk(out_samples == ex, "R9 resync samples", 64'(out_samples), 64'(ex));

        idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule